// File: doc/BRIEF.md
# Multi-Channel Event Timer with Shared Timebase

This block is a small memory-mapped timer. It has four 16-bit down-counting event channels and one 32-bit free-running up-counter. A single prescaler chain divides the system clock into 1 µs, 10 µs, 100 µs and 1 ms single-cycle strobes. Each event channel picks one of these strobes as its tick. The up-counter can also count raw system clock cycles. Software drives the block through a synchronous register port: address, write data and write enable go in, and combinational read data comes out.

Each event channel is loaded with a delay in ticks and can be enabled in one-shot or periodic mode. When it expires it raises a one-clock interrupt pulse on its own output. In periodic mode it then reloads the last written value and keeps going. In one-shot mode it stops and clears its own enable bit. The up-counter can be read at any time, so it serves as a timestamp.

Top module: `tick_timer`

## Requirements
- R1: The control register is at offset 0x00. Bits 19..16 enable channels D, C, B, A. Bits 15..12 set the mode of channels D, C, B, A, where 1 means periodic and 0 means one-shot. Bits 10:8 select the up-counter source. The channel sources are at bits 7:6 (D), 5:4 (C), 3:2 (B) and 1:0 (A). Unused bits are not stored and read as 0.
- R2: The channel source codes are 0 for 1 µs, 1 for 10 µs, 2 for 100 µs and 3 for 1 ms. One 1 µs tick lasts DIV_1US clock cycles, where DIV_1US must be at least 2. Each longer tick is ten of the next shorter one.
- R3: The count registers of channels A, B, C and D are at offsets 0x04, 0x08, 0x0C and 0x10. A write stores the low 16 bits both as the reload value and as the current count. A read returns the current count, zero-extended.
- R4: With reload value N−1 (N from 1 to 0xFFFF) and periodic mode, an enabled channel pulses its interrupt once every N selected ticks.
- R5: In one-shot mode a channel pulses exactly once. It then clears its own enable bit and holds its count at 0.
- R6: Every interrupt pulse is high for exactly one clock cycle.
- R7: While its enable bit is 0, a channel holds its count and raises no pulse. When the enable bit goes from 0 to 1, the count restarts from the last written value, and that value is readable in the cycle after the enable takes effect.
- R8: The up-counter is read at offset 0x14. It adds 1 per selected tick. Source codes are 0 for the system clock, 1 for 1 µs, 2 for 10 µs, 3 for 100 µs and 4 for 1 ms. Codes 5 to 7 hold the counter still.
- R9: After reset, every register and count reads 0 and all interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe, sampled on the rising clock edge |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 4 | One-cycle expiry pulses; bit 0 is channel A, bit 3 is channel D |

## Verification
The bench measures the cycle distance between consecutive periodic pulses for every tick source. This catches a design that is off by one in the reload, wrong in the divide-by-ten cascade, or miswired in the source decode, because each of those gives the wrong spacing. The one-shot case checks for exactly one pulse and a cleared enable bit; a design that does not clear the bit keeps pulsing. A disabled channel must stay frozen and silent. On re-enable, the count must read back as the last written value; a design that resumes from the frozen count instead returns a lower value. The up-counter is checked at four source codes, including one of the hold codes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int REG_W    = 32;
  localparam int CH_N     = 4;
  localparam int CNT_W    = 16;
  localparam int FREE_W   = 32;
  localparam int N_BASE   = 4;
  localparam int CSEL_W   = $clog2(N_BASE);
  localparam int FSEL_W   = 3;
  localparam int EN_LSB   = 16;
  localparam int MODE_LSB = 12;
  localparam int FSEL_LSB = 8;
  localparam int CSEL_LSB = 0;
  localparam int OFF_CTRL = 0;
  localparam int OFF_FREE = 4 * (CH_N + 1);

  localparam logic [REG_W-1:0] CTRL_MASK = REG_W'(
      (((1 << CH_N) - 1) << EN_LSB) |
      (((1 << CH_N) - 1) << MODE_LSB) |
      (((1 << FSEL_W) - 1) << FSEL_LSB) |
      (((1 << (CH_N * CSEL_W)) - 1) << CSEL_LSB));

  function automatic int chan_off(input int idx);
    return 4 * (idx + 1);
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DIV_1US = 50,
  parameter int STAGES  = 3,
  parameter int RATIO   = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [STAGES:0] tick_o
);
  localparam int BW = $clog2(DIV_1US);
  localparam int RW = $clog2(RATIO);

  if (DIV_1US < 2) begin : g_bad_div
    initial $error("DIV_1US must be at least 2");
  end

  logic [BW-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     base_q <= '0;
    else if (tick_o[0]) base_q <= '0;
    else             base_q <= base_q + BW'(1);
  end

  assign tick_o[0] = (base_q == BW'(DIV_1US - 1));

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic [RW-1:0] dec_q;
    logic          wrap;
    assign wrap = (dec_q == RW'(RATIO - 1));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        dec_q <= '0;
      else if (tick_o[k]) dec_q <= wrap ? '0 : dec_q + RW'(1);
    end
    assign tick_o[k+1] = tick_o[k] && wrap;

    // a slower strobe never sits on two adjacent cycles
    p_slow_strobe_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o[k+1] |=> !tick_o[k+1]);
  end
endmodule

// File: rtl/tmr_event_chan.sv
module tmr_event_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             periodic_i,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q, load_q;
  logic             en_d_q, irq_q;
  logic             restart, expire;

  assign restart = en_i && !en_d_q;
  assign expire  = en_i && en_d_q && tick_i && (cnt_q == '0) && !wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      load_q <= '0;
      en_d_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      en_d_q <= en_i;
      irq_q  <= expire;
      if (wr_i) begin
        load_q <= wdata_i;
        cnt_q  <= wdata_i;
      end else if (restart) begin
        cnt_q <= load_q;
      end else if (en_i && tick_i) begin
        if (cnt_q == '0) cnt_q <= periodic_i ? load_q : '0;
        else             cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign irq_o  = irq_q;
  assign done_o = expire && !periodic_i;

  p_irq_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
  p_irq_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> $past(en_i));
  p_hold_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !wr_i) |=> $stable(cnt_q));
  p_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart && !wr_i) |=> (cnt_q == $past(load_q)));
  p_reload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && periodic_i) |=> (cnt_q == $past(load_q)));
endmodule

// File: rtl/tmr_free_ctr.sv
module tmr_free_ctr #(
  parameter int W      = 32,
  parameter int SEL_W  = 3,
  parameter int N_TICK = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [N_TICK-1:0] ticks_i,
  output logic [W-1:0]      cnt_o
);
  logic [N_TICK:0] src;
  logic            step;
  logic [W-1:0]    cnt_q;

  assign src  = {ticks_i, 1'b1};
  assign step = (sel_i <= SEL_W'(N_TICK)) ? src[sel_i] : 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (step) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;

  p_sysclk_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == '0) |=> (cnt_q == $past(cnt_q) + W'(1)));
  p_hold_code_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i > SEL_W'(N_TICK)) |=> $stable(cnt_q));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tmr_pkg::*;
#(
  parameter int DIV_1US = 50,
  parameter int ADDR_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              we_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [CH_N-1:0]   irq_o
);
  logic [REG_W-1:0]  ctrl_q;
  logic [N_BASE-1:0] base_tick;
  logic [CH_N-1:0]   done;
  logic [CNT_W-1:0]  cnt [CH_N];
  logic [FREE_W-1:0] free_cnt;
  logic              ctrl_wr;

  assign ctrl_wr = we_i && (addr_i == ADDR_W'(OFF_CTRL));

  tmr_prescaler #(.DIV_1US(DIV_1US), .STAGES(N_BASE - 1), .RATIO(10)) i_presc (
    .clk_i, .rst_ni, .tick_o(base_tick));

  // software write wins over a one-shot self-clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      for (int i = 0; i < CH_N; i++)
        if (done[i]) ctrl_q[EN_LSB+i] <= 1'b0;
      if (ctrl_wr) ctrl_q <= wdata_i & CTRL_MASK;
    end
  end

  for (genvar g = 0; g < CH_N; g++) begin : g_ch
    logic [CSEL_W-1:0] sel;
    assign sel = ctrl_q[CSEL_LSB + g*CSEL_W +: CSEL_W];

    tmr_event_chan #(.CNT_W(CNT_W)) i_chan (
      .clk_i,
      .rst_ni,
      .en_i      (ctrl_q[EN_LSB+g]),
      .periodic_i(ctrl_q[MODE_LSB+g]),
      .tick_i    (base_tick[sel]),
      .wr_i      (we_i && (addr_i == ADDR_W'(chan_off(g)))),
      .wdata_i   (wdata_i[CNT_W-1:0]),
      .cnt_o     (cnt[g]),
      .irq_o     (irq_o[g]),
      .done_o    (done[g]));

    p_oneshot_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done[g] && !ctrl_wr) |=> !ctrl_q[EN_LSB+g]);
  end

  tmr_free_ctr #(.W(FREE_W), .SEL_W(FSEL_W), .N_TICK(N_BASE)) i_free (
    .clk_i, .rst_ni,
    .sel_i  (ctrl_q[FSEL_LSB +: FSEL_W]),
    .ticks_i(base_tick),
    .cnt_o  (free_cnt));

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFF_CTRL)) rdata_o = ctrl_q;
    if (addr_i == ADDR_W'(OFF_FREE)) rdata_o = REG_W'(free_cnt);
    for (int i = 0; i < CH_N; i++)
      if (addr_i == ADDR_W'(chan_off(i))) rdata_o = REG_W'(cnt[i]);
  end

  p_ctrl_unused_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q & ~CTRL_MASK) == '0);
endmodule

// File: tb/test_tick_timer.sv
module test_tick_timer;
  localparam int DIV = 2;
  localparam int WD  = 150000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] rdata_o;
  logic [3:0]  irq_o;

  tick_timer #(.DIV_1US(DIV), .ADDR_W(5)) i_tick_timer (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i, .rdata_o, .irq_o);

  always #10 clk_i = ~clk_i;

  int checks = 0, failures = 0, cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard: expected periodic intervals, popped by the monitor
  int exp_ch[$];
  int exp_iv[$];
  int last_t[4];
  bit last_v[4];
  int pulses[4];
  int width_err = 0;
  logic [3:0] prev_irq = '0;

  always @(negedge clk_i) begin
    for (int c = 0; c < 4; c++) begin
      if (irq_o[c]) begin
        pulses[c]++;
        if (last_v[c] && exp_ch.size() > 0 && exp_ch[0] == c) begin
          int iv;
          iv = exp_iv.pop_front();
          void'(exp_ch.pop_front());
          chk("R4 periodic interval", 32'(cyc - last_t[c]), 32'(iv));
        end
        last_t[c] = cyc;
        last_v[c] = 1'b1;
      end
    end
    if ((irq_o & prev_irq) != 0) width_err++;
    prev_irq = irq_o;
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = 5'(a); wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr_i = 5'(a);
    #1 d = rdata_o;
  endtask

  function automatic int scale(input int sel);
    case (sel)
      0: return 1;
      1: return 10;
      2: return 100;
      default: return 1000;
    endcase
  endfunction

  task automatic run_periodic(input int ch, input int sel, input int load, input int n);
    logic [31:0] v;
    wr(4*(ch+1), 32'(load));
    rd(4*(ch+1), v);
    chk("R3 count readback after load", v, 32'(load));
    last_v[ch] = 1'b0;
    for (int k = 0; k < n; k++) begin
      exp_ch.push_back(ch);
      exp_iv.push_back((load + 1) * scale(sel) * DIV);
    end
    // R2: source code sel applied to channel ch
    wr(0, (32'h1 << (16+ch)) | (32'h1 << (12+ch)) | (32'(sel) << (2*ch)));
    while (exp_ch.size() != 0) @(negedge clk_i);
    wr(0, 32'h0);
  endtask

  initial begin
    repeat (WD) @(posedge clk_i);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v0, v1, v2;
    int p;
    repeat (3) @(negedge clk_i);
    rd(0, v0);  chk("R9 ctrl reset", v0, 32'h0);
    rd(4, v0);  chk("R9 count A reset", v0, 32'h0);
    rd(20, v0); chk("R9 up-counter reset", v0, 32'h0);
    chk("R9 irq reset", 32'(irq_o), 32'h0);
    rst_ni = 1'b1;

    wr(0, 32'hFFFF_FFFF);
    rd(0, v0); chk("R1 ctrl stored bits", v0, 32'h000F_F7FF);
    wr(0, 32'h0);

    run_periodic(0, 0, 4, 3);
    run_periodic(1, 1, 2, 3);
    run_periodic(2, 2, 0, 2);
    run_periodic(3, 3, 0, 2);
    run_periodic(1, 0, 1, 2);

    // R5 one-shot on channel A
    wr(4, 32'd3);
    p = pulses[0];
    wr(0, 32'h0001_0000);
    repeat (60) @(negedge clk_i);
    chk("R5 one pulse", 32'(pulses[0] - p), 32'd1);
    rd(0, v0); chk("R5 enable cleared", v0, 32'h0);
    rd(4, v0); chk("R5 count at zero", v0, 32'h0);

    // R7 disable on channel B
    wr(8, 32'h0);
    wr(0, 32'h0002_2004);
    repeat (100) @(negedge clk_i);
    wr(0, 32'h0);
    p = pulses[1];
    repeat (100) @(negedge clk_i);
    chk("R7 no pulse while off", 32'(pulses[1]), 32'(p));
    wr(8, 32'h0123);
    rd(8, v0); chk("R3 load while off", v0, 32'h0123);
    wr(0, 32'h0002_2000);
    repeat (30) @(negedge clk_i);
    rd(8, v0); chk("R3 count decrements", 32'(v0 < 32'h0123), 32'd1);
    wr(0, 32'h0);
    rd(8, v1);
    repeat (20) @(negedge clk_i);
    rd(8, v2); chk("R7 count frozen", v2, v1);
    wr(0, 32'h0002_2000);
    @(negedge clk_i);
    rd(8, v0); chk("R7 restart from load", v0, 32'h0123);
    wr(0, 32'h0);

    // R8 up-counter sources
    rd(20, v1); repeat (10) @(negedge clk_i); rd(20, v2);
    chk("R8 sysclk rate", v2 - v1, 32'd10);
    wr(0, 32'h0000_0100);
    rd(20, v1); repeat (200) @(negedge clk_i); rd(20, v2);
    chk("R8 1us rate", v2 - v1, 32'd100);
    wr(0, 32'h0000_0400);
    rd(20, v1); repeat (4000) @(negedge clk_i); rd(20, v2);
    chk("R8 1ms rate", v2 - v1, 32'd2);
    wr(0, 32'h0000_0600);
    rd(20, v1); repeat (50) @(negedge clk_i); rd(20, v2);
    chk("R8 hold code", v2 - v1, 32'd0);

    chk("R6 pulse width", 32'(width_err), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule